// File: doc/BRIEF.md
# Memory Debug Address Tap

The tap sits beside a memory controller. On each memory-bus transaction it drives a 16-bit slice of the 30-bit physical address onto a debug port. A bus analyser that records this port, together with the memory pins, can then rebuild the full address.

The slice depends on the transaction target and on the configured data-bus width:

- **SDRAM/DRAM targets.** The slice supplies the upper address bits. The column address and chip selects do not carry these bits. The slice is published with the column-address phase.
- **ROM, Flash and expansion-port targets.** The slice supplies bits [23:8] of a 24-bit address. The ROM address lines give the rest. The slice is published with the ROM-address phase.

The bus width sets the address granularity. The low address bits that a wider bus never resolves are dropped, and the remaining bits are shifted down before the slice is taken.

The function is off unless it is enabled. A low level on an active-low strap pin, sampled during reset, enables it. A software enable bit also enables it, and the two are combined by an OR. The outputs are registered. The debug value and its qualifier strobe therefore appear one clock after the address-phase strobe, and they stay aligned with each other.

Top module: `dbg_addr_tap`

## Requirements
- R1: The strap enable is the inverse of `strap_n` as sampled in the last clock cycle with `rst` high. Changes on `strap_n` while `rst` is low have no effect on the outputs.
- R2: The block is enabled when the latched strap enable is 1 or `sw_en` is 1. Either source alone is enough.
- R3: The registered outputs are updated one cycle after the block is disabled. `dbg_addr` becomes 16'h0000 and `dbg_vld` becomes 0.
- R4: For target `tgt`=0 (SDRAM/DRAM), the captured value is bits [29:14] of the unit address. The unit address is `phys_addr` shifted right by the granularity shift, with zeros filled in at the top.
- R5: For target `tgt`=1 (ROM/Flash/expansion port), the captured value is bits [23:8] of the unit address. Here the unit address is `phys_addr[23:0]` shifted right by the granularity shift.
- R6: `bus_w` sets the granularity shift as follows:
  - 2'b00 (8-bit bus): shift 0.
  - 2'b01 (32-bit bus): shift 2.
  - 2'b10 (64-bit bus): shift 3.
  - 2'b11: treated as the 8-bit case, shift 0.
- R7: While the block is enabled, `dbg_vld` is 1 in the cycle after a cycle in which the phase strobe matching `tgt` was high, and 0 otherwise. For `tgt`=0 the matching strobe is `col_stb`; for `tgt`=1 it is `rom_stb`. A strobe of the other phase captures nothing.
- R8: While the block is enabled, `dbg_addr` holds its last captured value through cycles that have no matching strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_n | input | 1 | Active-low enable strap, sampled during reset |
| sw_en | input | 1 | Software enable bit |
| phys_addr | input | 30 | Physical address of the current transaction |
| tgt | input | 1 | Target type: 0 SDRAM/DRAM, 1 ROM/Flash/expansion |
| bus_w | input | 2 | Data-bus width code |
| col_stb | input | 1 | Column-address phase strobe |
| rom_stb | input | 1 | ROM-address phase strobe |
| dbg_addr | output | 16 | Debug address slice |
| dbg_vld | output | 1 | Qualifier, one cycle per captured phase |

## Verification
Every result of the tap is due exactly one clock after its cause:

- a strobed phase produces its slice and its qualifier at the next edge;
- a change of the enable clears the outputs at the next edge.

The bench drives each stimulus on a falling edge and samples at the following falling edge. A captured slice is therefore checked half a cycle after the edge that registered it. In the next falling-edge sample, after the strobe has been removed, the bench checks that the qualifier has dropped and the value is held. Strap effects are checked only after a reset sequence, whose last cycle sets the latch. A strobe of the wrong phase, and a late change of the strap, are each checked in the cycle that follows them.

// File: rtl/dbg_addr_pkg.sv
package dbg_addr_pkg;

    localparam int PA_W      = 30;   // physical address width
    localparam int DBG_W     = 16;   // debug port width
    localparam int ROM_PA_W  = 24;   // rebuilt ROM-side address width
    localparam int SD_LSB    = 14;   // first unit-address bit shown for SDRAM
    localparam int ROM_LSB   = 8;    // first unit-address bit shown for ROM

    typedef enum logic {
        TGT_SDRAM = 1'b0,
        TGT_ROM   = 1'b1
    } tgt_e;

    typedef enum logic [1:0] {
        BW_8   = 2'b00,
        BW_32  = 2'b01,
        BW_64  = 2'b10,
        BW_RSV = 2'b11
    } bus_w_e;

    typedef struct packed {
        tgt_e   tgt;
        bus_w_e bw;
        logic   stb;
    } phase_t;

    // Low address bits that the data-bus width never resolves.
    function automatic int unsigned gran_shift(bus_w_e bw);
        case (bw)
            BW_32:   return 2;
            BW_64:   return 3;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/dbg_addr_enable.sv
module dbg_addr_enable (
    input  logic clk,
    input  logic rst,
    input  logic strap_n,
    input  logic sw_en,
    output logic en
);
    logic strap_on;

    // Follows the strap while reset is held; frozen afterwards.
    always_ff @(posedge clk) begin
        if (rst) strap_on <= ~strap_n;
    end

    assign en = strap_on | sw_en;

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(strap_on)); // R1

endmodule

// File: rtl/dbg_addr_slice.sv
module dbg_addr_slice
    import dbg_addr_pkg::*;
#(
    parameter int AW  = PA_W,
    parameter int DW  = DBG_W,
    parameter int RW  = ROM_PA_W,
    parameter int SDL = SD_LSB,
    parameter int RML = ROM_LSB
) (
    input  logic [AW-1:0] addr,
    input  tgt_e          tgt,
    input  bus_w_e        bw,
    output logic [DW-1:0] slice
);
    localparam int PAD_W = AW - RW;

    logic [AW-1:0] base;
    logic [AW-1:0] unit;

    always_comb begin
        if (tgt == TGT_ROM) base = {{PAD_W{1'b0}}, addr[RW-1:0]};
        else                base = addr;
        unit = base >> gran_shift(bw);
        if (tgt == TGT_ROM) slice = unit[RML +: DW];
        else                slice = unit[SDL +: DW];
    end

endmodule

// File: rtl/dbg_addr_tap.sv
module dbg_addr_tap
    import dbg_addr_pkg::*;
#(
    parameter int AW = PA_W,
    parameter int DW = DBG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strap_n,
    input  logic          sw_en,
    input  logic [AW-1:0] phys_addr,
    input  logic          tgt,
    input  logic [1:0]    bus_w,
    input  logic          col_stb,
    input  logic          rom_stb,
    output logic [DW-1:0] dbg_addr,
    output logic          dbg_vld
);
    logic          en;
    phase_t        ph;
    logic [DW-1:0] slice;

    dbg_addr_enable u_en (
        .clk     (clk),
        .rst     (rst),
        .strap_n (strap_n),
        .sw_en   (sw_en),
        .en      (en)
    );

    always_comb begin
        ph.tgt = tgt_e'(tgt);
        ph.bw  = bus_w_e'(bus_w);
        ph.stb = (ph.tgt == TGT_ROM) ? rom_stb : col_stb;
    end

    dbg_addr_slice #(.AW(AW), .DW(DW)) u_slice (
        .addr  (phys_addr),
        .tgt   (ph.tgt),
        .bw    (ph.bw),
        .slice (slice)
    );

    // The output register doubles as the one-clock delay of the phase strobe.
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            dbg_addr <= '0;
            dbg_vld  <= 1'b0;
        end else begin
            dbg_vld <= ph.stb;
            if (ph.stb) dbg_addr <= slice;
        end
    end

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> (dbg_addr == '0 && !dbg_vld)); // R3

    AST_VLD_FROM_STB: assert property (@(posedge clk) disable iff (rst)
        dbg_vld |-> $past(en) && ($past(tgt) ? $past(rom_stb) : $past(col_stb))); // R7

    AST_STB_GIVES_VLD: assert property (@(posedge clk) disable iff (rst)
        $past(en) && !$past(rst) && ($past(tgt) ? $past(rom_stb) : $past(col_stb)) |-> dbg_vld); // R7

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        $past(en) && !dbg_vld |-> $stable(dbg_addr)); // R8

endmodule

// File: tb/sim_dbg_addr_tap.sv
`timescale 1ns/1ps
module sim_dbg_addr_tap;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_n = 1'b1;
    logic        sw_en = 1'b0;
    logic [29:0] phys_addr = '0;
    logic        tgt = 1'b0;
    logic [1:0]  bus_w = 2'b00;
    logic        col_stb = 1'b0;
    logic        rom_stb = 1'b0;
    logic [15:0] dbg_addr;
    logic        dbg_vld;

    int checks = 0;
    int errors = 0;
    logic [15:0] last = '0;

    always #4 clk = ~clk;

    dbg_addr_tap u0 (
        .clk(clk), .rst(rst), .strap_n(strap_n), .sw_en(sw_en),
        .phys_addr(phys_addr), .tgt(tgt), .bus_w(bus_w),
        .col_stb(col_stb), .rom_stb(rom_stb),
        .dbg_addr(dbg_addr), .dbg_vld(dbg_vld)
    );

    function automatic logic [15:0] expect_slice(logic t, logic [1:0] w, logic [29:0] a);
        int sh;
        logic [29:0] u;
        sh = (w == 2'b01) ? 2 : (w == 2'b10) ? 3 : 0;
        if (t) begin
            u = {6'd0, a[23:0]} >> sh;
            return u[23:8];
        end
        u = a >> sh;
        return u[29:14];
    endfunction

    task automatic chk(string req, logic [16:0] act, logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s vld/addr act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic s);
        @(negedge clk);
        rst = 1'b1; strap_n = s; col_stb = 0; rom_stb = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        last = '0;
    endtask

    // Matching strobe for one cycle; checks capture and hold.
    task automatic phase(string req, logic t, logic [1:0] w, logic [29:0] a, logic on);
        logic [15:0] e;
        e = on ? expect_slice(t, w, a) : 16'h0;
        tgt = t; bus_w = w; phys_addr = a;
        col_stb = ~t; rom_stb = t;
        @(negedge clk);
        col_stb = 0; rom_stb = 0;
        chk(req, {dbg_vld, dbg_addr}, {on, e});
        @(negedge clk);
        chk({req, " R8"}, {dbg_vld, dbg_addr}, {1'b0, e});
        last = e;
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none

        // R1/R3: strap high, no software enable -> off
        do_reset(1'b1);
        chk("R3 reset", {dbg_vld, dbg_addr}, 17'h0);
        phase("R1 R3 off", 1'b0, 2'b00, 30'h3FFFFFFF, 1'b0);

        // R2: software enable alone
        @(negedge clk); sw_en = 1;
        @(negedge clk);
        phase("R2 R4", 1'b0, 2'b00, 30'h12345678, 1'b1);

        // R3: disable mid-run clears next cycle
        sw_en = 0;
        @(negedge clk);
        chk("R3 disable", {dbg_vld, dbg_addr}, 17'h0);

        // R1: strap low enables; later strap change ignored
        do_reset(1'b0);
        @(negedge clk); strap_n = 1;
        @(negedge clk);
        phase("R1 strap", 1'b1, 2'b00, 30'h2ABCDEF1, 1'b1);

        // R7: wrong-phase strobes capture nothing
        tgt = 0; phys_addr = 30'h15555555; rom_stb = 1;
        @(negedge clk);
        rom_stb = 0;
        chk("R7 wrong col", {dbg_vld, dbg_addr}, {1'b0, last});
        tgt = 1; col_stb = 1;
        @(negedge clk);
        col_stb = 0;
        chk("R7 wrong rom", {dbg_vld, dbg_addr}, {1'b0, last});

        // R4/R5/R6: sweep target, width, address patterns
        for (int t = 0; t < 2; t++) begin
            for (int w = 0; w < 4; w++) begin
                for (int i = 0; i < 34; i++) begin
                    logic [29:0] a;
                    case (i)
                        30: a = 30'h3FFFFFFF;
                        31: a = 30'h2AAAAAAA;
                        32: a = 30'h15555555;
                        33: a = 30'h12345678;
                        default: a = 30'h1 << i;
                    endcase
                    phase(t ? "R5 R6" : "R4 R6", t[0], w[1:0], a, 1'b1);
                end
            end
        end

        // R7: back-to-back strobes give back-to-back qualifiers
        tgt = 0; bus_w = 2'b10; phys_addr = 30'h3F0F0F0F; col_stb = 1;
        @(negedge clk);
        chk("R7 b2b 1", {dbg_vld, dbg_addr}, {1'b1, expect_slice(1'b0, 2'b10, 30'h3F0F0F0F)});
        phys_addr = 30'h00F0F0F0;
        @(negedge clk);
        col_stb = 0;
        chk("R7 b2b 2", {dbg_vld, dbg_addr}, {1'b1, expect_slice(1'b0, 2'b10, 30'h00F0F0F0)});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule